// File: doc/BRIEF.md
# ADC Regular Conversion Sequencer

This block drives an analog-to-digital converter through a list of up to sixteen conversion slots. A sequence starts on a software start pulse or on a chosen edge of one of sixteen external trigger inputs. Either start counts only while the block is enabled and idle. For each slot the sequencer presents that slot's channel number. It then holds a sample phase whose length comes from the channel's own sample-time code. Next comes a conversion phase whose length depends on the chosen resolution. When the conversion phase ends, the sequencer captures the converter's result bus, formats it into a 16-bit data word and sets an end-of-conversion flag. Reading the data word clears that flag.

In single mode the list is walked once per start. In continuous mode the walk begins again at the first slot after the last slot finishes. Clearing the enable input stops any sequence at once and returns the block to idle.

The controller has four states: IDLE, SAMPLE, CONVERT and STORE. The transitions are as follows:
- start (IDLE to SAMPLE, taken on an accepted start request).
- sample_done (SAMPLE to CONVERT, taken when the sample timer expires).
- convert_done (CONVERT to STORE, taken when the conversion timer expires; the result is captured here).
- next_slot (STORE to SAMPLE, taken when slots remain).
- wrap (STORE to SAMPLE at slot 0, taken at the end of a pass in continuous mode).
- finish (STORE to IDLE, taken at the end of a pass in single mode).
- abort (any state to IDLE, taken when enable is low).

Top module: `adc_seq_top`

## Requirements
- R1: The conversion phase (`converting` high) lasts 15, 13, 11 or 9 clock cycles for `res_sel` 00, 01, 10 and 11. These codes mean 12, 10, 8 and 6 bits.
- R2: The sample phase (`sampling` high) lasts 3, 15, 28, 56, 84, 112, 144 or 480 cycles. The length is set by the 3-bit sample code, 000 through 111, of the channel in the current slot. Channel c takes its code from bits [3c+2:3c] of `smp_code`.
- R3: `trig_mode` sets how the input `trig_in[trig_sel]` starts a sequence. 00 means the trigger never starts one. 01 starts on a rising edge, 10 on a falling edge and 11 on either edge. The other trigger inputs have no effect.
- R4: One pass converts the slots 0 through `seq_last` in ascending order. That is `seq_last`+1 conversions. Slot s holds its channel in bits [5s+4:5s] of `seq_chan`, and `chan_sel` shows that channel during the slot.
- R5: With `cont_mode` low, the block returns to idle (`busy` low) after one pass.
- R6: With `cont_mode` high, the pass restarts at slot 0 after the last slot, with no new start.
- R7: Only the n low bits of `conv_result` are used, where n is the resolution. With `align_left` low the value sits at bit 0 of `data_out`. With `align_left` high its MSB sits at bit 15. All other bits are 0.
- R8: `data_out` and a set `eoc` appear in the cycle after the conversion phase ends. A one-cycle `data_read` pulse clears `eoc` on the next cycle.
- R9: A start request while `enable` is low is ignored.
- R10: A start request while a sequence runs is ignored. A single-mode pass still ends in idle and does not run again.
- R11: When `enable` goes low during a sequence, the block is idle on the next cycle.
- R12: After reset the block is idle, with `eoc` low, `data_out` zero and both phase outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; low aborts and holds the block idle |
| cont_mode | input | 1 | 1 restarts the list after each pass |
| align_left | input | 1 | 1 places the result MSB at bit 15 |
| res_sel | input | 2 | Resolution code |
| trig_mode | input | 2 | External trigger edge selection |
| trig_sel | input | 4 | Index of the external trigger input that is used |
| trig_in | input | 16 | External trigger inputs |
| sw_start | input | 1 | Software start pulse |
| seq_last | input | 4 | Index of the last slot converted |
| seq_chan | input | 80 | Channel numbers of the slots, 5 bits per slot |
| smp_code | input | 57 | Sample-time codes of the channels, 3 bits per channel |
| conv_result | input | 12 | Converter result, valid at the end of the conversion phase |
| data_read | input | 1 | Data word read strobe; clears the end flag |
| chan_sel | output | 5 | Channel being converted |
| sampling | output | 1 | Sample phase active |
| converting | output | 1 | Conversion phase active |
| busy | output | 1 | A sequence is in progress |
| eoc | output | 1 | End-of-conversion flag |
| data_out | output | 16 | Formatted result word |

## Verification
Phase lengths are measured at the outputs for every resolution code and for several sample codes. The measured lengths separate the table lookups from each other and expose a phase that runs one cycle long or short. A three-slot list with different channels checks the slot order, the per-channel choice of sample code and the stop after `seq_last`. Continuous mode is checked by the wrap back to slot 0, which is then aborted by dropping enable. Each trigger mode gets both edges on the selected input, plus toggles on an unselected input. This separates rising, falling and disabled behaviour and catches a wrong input select. Start pulses sent while disabled or while busy show whether they are wrongly accepted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONVERT,
        ST_STORE
    } seq_state_t;

    localparam int PHASE_W = 9;

    function automatic logic [PHASE_W-1:0] smp_cycles(input logic [2:0] code);
        logic [PHASE_W-1:0] n;
        unique case (code)
            3'd0: n = 9'd3;
            3'd1: n = 9'd15;
            3'd2: n = 9'd28;
            3'd3: n = 9'd56;
            3'd4: n = 9'd84;
            3'd5: n = 9'd112;
            3'd6: n = 9'd144;
            default: n = 9'd480;
        endcase
        return n;
    endfunction

    function automatic logic [PHASE_W-1:0] conv_cycles(input logic [1:0] res);
        return 9'd15 - {6'd0, res, 1'b0};
    endfunction

    function automatic logic [4:0] res_bits(input logic [1:0] res);
        return 5'd12 - {2'd0, res, 1'b0};
    endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
    parameter int NUM_TRIG = 16,
    localparam int SEL_W = $clog2(NUM_TRIG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]    trig_sel,
    input  logic [1:0]          trig_mode,
    output logic                trig_fire
);

    logic sel_q;
    logic sel_q2;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            sel_q2 <= 1'b0;
        end else begin
            sel_q  <= trig_in[trig_sel];
            sel_q2 <= sel_q;
        end
    end

    assign rise = sel_q & ~sel_q2;
    assign fall = ~sel_q & sel_q2;

    always_comb begin
        unique case (trig_mode)
            2'b00: trig_fire = 1'b0;
            2'b01: trig_fire = rise;
            2'b10: trig_fire = fall;
            default: trig_fire = rise | fall;
        endcase
    end

    a_r3_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == 2'b00) |-> !trig_fire);

    a_r3_fire_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fire |-> (sel_q != sel_q2));

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - 1'b1;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
    parameter int RAW_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic [RAW_W-1:0]  raw,
    input  logic [1:0]        res,
    input  logic              align_left,
    output logic [DATA_W-1:0] word
);

    import adc_seq_pkg::*;

    logic [4:0]        nbits;
    logic [DATA_W-1:0] raw_ext;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] kept;
    logic [4:0]        lshift;

    always_comb begin
        nbits   = res_bits(res);
        raw_ext = {{(DATA_W-RAW_W){1'b0}}, raw};
        mask    = ({{(DATA_W-1){1'b0}}, 1'b1} << nbits) - 1'b1;
        kept    = raw_ext & mask;
        lshift  = 5'(DATA_W) - nbits;
        if (align_left) begin
            word = kept << lshift;
        end else begin
            word = kept;
        end
    end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int NUM_SLOT = 16,
    parameter int NUM_CH   = 19,
    parameter int NUM_TRIG = 16,
    parameter int CH_W     = 5,
    parameter int RAW_W    = 12,
    parameter int DATA_W   = 16,
    localparam int SLOT_W  = $clog2(NUM_SLOT),
    localparam int TSEL_W  = $clog2(NUM_TRIG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     cont_mode,
    input  logic                     align_left,
    input  logic [1:0]               res_sel,
    input  logic [1:0]               trig_mode,
    input  logic [TSEL_W-1:0]        trig_sel,
    input  logic [NUM_TRIG-1:0]      trig_in,
    input  logic                     sw_start,
    input  logic [SLOT_W-1:0]        seq_last,
    input  logic [NUM_SLOT*CH_W-1:0] seq_chan,
    input  logic [NUM_CH*3-1:0]      smp_code,
    input  logic [RAW_W-1:0]         conv_result,
    input  logic                     data_read,
    output logic [CH_W-1:0]          chan_sel,
    output logic                     sampling,
    output logic                     converting,
    output logic                     busy,
    output logic                     eoc,
    output logic [DATA_W-1:0]        data_out
);

    import adc_seq_pkg::*;

    seq_state_t           state_q;
    seq_state_t           state_d;
    logic [SLOT_W-1:0]    slot_q;
    logic [SLOT_W-1:0]    slot_d;
    logic                 trig_fire;
    logic                 start_req;
    logic                 tmr_done;
    logic                 tmr_load;
    logic [PHASE_W-1:0]   tmr_val;
    logic                 tmr_run;
    logic                 capture;
    logic [CH_W-1:0]      cur_chan;
    logic [CH_W-1:0]      nxt_chan;
    logic [CH_W-1:0]      code_idx;
    logic [2:0]           nxt_code;
    logic [DATA_W-1:0]    fmt_word;
    logic [DATA_W-1:0]    data_q;
    logic                 eoc_q;

    adc_seq_trig #(.NUM_TRIG(NUM_TRIG)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_sel  (trig_sel),
        .trig_mode (trig_mode),
        .trig_fire (trig_fire)
    );

    assign start_req = sw_start | trig_fire;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = ST_SAMPLE;
                    slot_d  = '0;
                end
            end
            ST_SAMPLE: begin
                if (tmr_done) state_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (tmr_done) state_d = ST_STORE;
            end
            ST_STORE: begin
                if (slot_q != seq_last) begin
                    state_d = ST_SAMPLE;
                    slot_d  = slot_q + 1'b1;
                end else if (cont_mode) begin
                    state_d = ST_SAMPLE;
                    slot_d  = '0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!enable) begin
            state_d = ST_IDLE;
            slot_d  = slot_q;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Channel and sample-code lookup for the slot about to be entered
    assign cur_chan = seq_chan[32'(slot_q) * CH_W +: CH_W];
    assign nxt_chan = seq_chan[32'(slot_d) * CH_W +: CH_W];
    assign code_idx = (32'(nxt_chan) < NUM_CH) ? nxt_chan : '0;
    assign nxt_code = smp_code[32'(code_idx) * 3 +: 3];

    // Phase timer control
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state_d == ST_SAMPLE && state_q != ST_SAMPLE) begin
            tmr_load = 1'b1;
            tmr_val  = smp_cycles(nxt_code);
        end else if (state_d == ST_CONVERT && state_q != ST_CONVERT) begin
            tmr_load = 1'b1;
            tmr_val  = conv_cycles(res_sel);
        end
    end

    assign tmr_run = (state_q == ST_SAMPLE) || (state_q == ST_CONVERT);

    adc_seq_timer #(.W(PHASE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .done     (tmr_done)
    );

    adc_seq_fmt #(.RAW_W(RAW_W), .DATA_W(DATA_W)) u_fmt (
        .raw        (conv_result),
        .res        (res_sel),
        .align_left (align_left),
        .word       (fmt_word)
    );

    assign capture = (state_q == ST_CONVERT) && tmr_done && enable;

    // Result word and end flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            eoc_q  <= 1'b0;
        end else begin
            if (capture) begin
                data_q <= fmt_word;
                eoc_q  <= 1'b1;
            end else if (data_read) begin
                eoc_q  <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        sampling   = 1'b0;
        converting = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy       = 1'b0;
            ST_SAMPLE:  sampling   = 1'b1;
            ST_CONVERT: converting = 1'b1;
            ST_STORE:   ;
            default:    busy       = 1'b0;
        endcase
        chan_sel = cur_chan;
        eoc      = eoc_q;
        data_out = data_q;
    end

    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_IDLE));

    a_r1_sample_then_convert: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && tmr_done && enable) |=> (state_q == ST_CONVERT));

    a_r8_eoc_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> eoc_q);

    a_r10_busy_slot_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_req && (state_q == ST_SAMPLE || state_q == ST_CONVERT))
        |=> $stable(slot_q));

    a_r12_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sampling, converting}));

    a_r4_slot_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |-> (slot_q <= seq_last));

endmodule

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cont_mode = 1'b0;
    logic        align_left = 1'b0;
    logic [1:0]  res_sel = 2'b00;
    logic [1:0]  trig_mode = 2'b00;
    logic [3:0]  trig_sel = 4'd0;
    logic [15:0] trig_in = '0;
    logic        sw_start = 1'b0;
    logic [3:0]  seq_last = 4'd0;
    logic [79:0] seq_chan = '0;
    logic [56:0] smp_code = '0;
    logic [11:0] conv_result = '0;
    logic        data_read = 1'b0;
    logic [4:0]  chan_sel;
    logic        sampling;
    logic        converting;
    logic        busy;
    logic        eoc;
    logic [15:0] data_out;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    adc_seq_top dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cont_mode(cont_mode),
        .align_left(align_left), .res_sel(res_sel), .trig_mode(trig_mode),
        .trig_sel(trig_sel), .trig_in(trig_in), .sw_start(sw_start),
        .seq_last(seq_last), .seq_chan(seq_chan), .smp_code(smp_code),
        .conv_result(conv_result), .data_read(data_read), .chan_sel(chan_sel),
        .sampling(sampling), .converting(converting), .busy(busy), .eoc(eoc),
        .data_out(data_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
    endtask

    task automatic read_data();
        @(negedge clk) data_read = 1'b1;
        @(negedge clk) data_read = 1'b0;
    endtask

    task automatic set_slot(input int s, input logic [4:0] ch);
        seq_chan[s*5 +: 5] = ch;
    endtask

    // Waits for a sample phase, returns its length, the conversion length and channel.
    task automatic measure(output int s_len, output int c_len, output logic [4:0] ch);
        int guard = 0;
        s_len = 0;
        c_len = 0;
        while (!sampling && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        ch = chan_sel;
        while (sampling) begin
            s_len++;
            @(negedge clk);
        end
        while (converting) begin
            c_len++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12 busy", busy, 0);
        chk("R12 eoc", eoc, 0);
        chk("R12 data", data_out, 0);
        chk("R12 phases", {sampling, converting}, 0);
    endtask

    task automatic t_single();
        int s, c;
        logic [4:0] ch;
        seq_last = 0; set_slot(0, 0); res_sel = 2'b00; align_left = 0;
        conv_result = 12'hABC;
        pulse_start();
        measure(s, c, ch);
        chk("R2 sample len code0", s, 3);
        chk("R1 conv len 12b", c, 15);
        chk("R4 channel slot0", ch, 0);
        chk("R8 eoc set", eoc, 1);
        chk("R7 right 12b", data_out, 16'h0ABC);
        repeat (3) @(negedge clk);
        chk("R5 idle after pass", busy, 0);
        read_data();
        chk("R8 eoc cleared", eoc, 0);
    endtask

    task automatic t_res();
        int s, c;
        logic [4:0] ch;
        logic [1:0] rs [4] = '{2'b11, 2'b01, 2'b10, 2'b00};
        logic       al [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
        int         cl [4] = '{9, 13, 11, 15};
        logic [15:0] ex [4] = '{16'hF000, 16'h02BC, 16'hBC00, 16'hABC0};
        conv_result = 12'hABC;
        for (int i = 0; i < 4; i++) begin
            res_sel = rs[i]; align_left = al[i];
            pulse_start();
            measure(s, c, ch);
            chk("R1 conv len", c, cl[i]);
            chk("R7 formatted word", data_out, ex[i]);
            wait_idle();
            read_data();
        end
        res_sel = 2'b00; align_left = 0;
    endtask

    task automatic t_list();
        int s, c;
        logic [4:0] ch;
        logic [4:0] chans [3] = '{5'd5, 5'd2, 5'd9};
        int         lens  [3] = '{15, 56, 480};
        seq_last = 2;
        for (int i = 0; i < 3; i++) set_slot(i, chans[i]);
        set_slot(3, 5'd7);
        pulse_start();
        for (int i = 0; i < 3; i++) begin
            measure(s, c, ch);
            chk("R4 slot order", ch, chans[i]);
            chk("R2 per-channel sample len", s, lens[i]);
        end
        repeat (2) @(negedge clk);
        chk("R4 stops after last slot", busy, 0);
        read_data();
    endtask

    task automatic t_disabled();
        seq_last = 0; set_slot(0, 0);
        enable = 0;
        pulse_start();
        repeat (5) @(negedge clk);
        chk("R9 start ignored while disabled", busy, 0);
        enable = 1;
        @(negedge clk);
    endtask

    task automatic t_busy_start();
        int hits = 0;
        seq_last = 0; set_slot(0, 0);
        pulse_start();
        repeat (6) @(negedge clk);
        pulse_start();
        wait_idle();
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy) hits++;
        end
        chk("R10 start during sequence ignored", hits, 0);
        read_data();
    endtask

    task automatic t_cont();
        int s, c;
        logic [4:0] ch;
        seq_last = 1; set_slot(0, 5'd0); set_slot(1, 5'd5);
        cont_mode = 1;
        pulse_start();
        measure(s, c, ch); chk("R6 first slot", ch, 0);
        measure(s, c, ch); chk("R6 second slot", ch, 5);
        measure(s, c, ch); chk("R6 wrap to slot0", ch, 0);
        chk("R6 still running", busy, 1);
        enable = 0;
        @(negedge clk);
        chk("R11 abort to idle", busy, 0);
        cont_mode = 0;
        enable = 1;
        read_data();
    endtask

    task automatic expect_start(input string req, input logic exp, input int bitn, input logic val);
        int seen = 0;
        @(negedge clk) trig_in[bitn] = val;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk(req, seen, {31'd0, exp});
        wait_idle();
    endtask

    task automatic t_trig();
        seq_last = 0; set_slot(0, 0);
        trig_sel = 4'd3;
        trig_mode = 2'b01;
        expect_start("R3 rising starts", 1, 3, 1'b1);
        expect_start("R3 falling ignored in rising mode", 0, 3, 1'b0);
        trig_mode = 2'b10;
        expect_start("R3 rising ignored in falling mode", 0, 3, 1'b1);
        expect_start("R3 falling starts", 1, 3, 1'b0);
        trig_mode = 2'b11;
        expect_start("R3 both: rising", 1, 3, 1'b1);
        expect_start("R3 both: falling", 1, 3, 1'b0);
        trig_mode = 2'b00;
        expect_start("R3 disabled rising", 0, 3, 1'b1);
        expect_start("R3 disabled falling", 0, 3, 1'b0);
        trig_mode = 2'b11;
        expect_start("R3 other input ignored", 0, 4, 1'b1);
        expect_start("R3 other input ignored fall", 0, 4, 1'b0);
        trig_mode = 2'b00;
        read_data();
    endtask

    initial begin
        smp_code = '0;
        smp_code[5*3 +: 3] = 3'b001;
        smp_code[2*3 +: 3] = 3'b011;
        smp_code[9*3 +: 3] = 3'b111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        enable = 1'b1;
        @(negedge clk);
        t_single();
        t_res();
        t_list();
        t_disabled();
        t_busy_start();
        t_cont();
        t_trig();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule